// File: doc/BRIEF.md
# Descriptor-Driven Configuration Transfer Engine

This block moves configuration item data into system memory under the control of a descriptor that software places in memory. A one-cycle trigger carries the 64-bit address of that descriptor. The engine then reads the 16-byte descriptor through a byte-wide memory master port. The descriptor holds a control word, a byte count and a target address, each big-endian. The control word can switch the engine to a new item. It also chooses one of three actions: copy the item's bytes to the target, step past them without touching memory, or do nothing.

The items live in a small on-chip store that tracks the current item key and a byte offset into that item. The offset survives from one transfer to the next, so software can read a long item in pieces. Reading beyond the end of an item, or from an item that does not exist, fills the target with zeros. When the work is done, or a memory access fails, the engine writes a 32-bit status word back over the descriptor's control field and drops `busy`.

Top module: `cfg_dma_engine`

## Requirements
- R1: After reset `busy` is low and `mem_req` is low. The item store has key 0 selected at offset 0.
- R2: A `trig` pulse while idle raises `busy` on the next edge. The engine then reads descriptor bytes at the trigger address +0..+15 with `mem_we` low. The layout is big-endian: control word at +0, byte count at +4, 64-bit target address at +8. `busy` stays high until the status write-back is done.
- R3: A `trig` pulse while `busy` is high is ignored. It causes no fetch, no data move and no write-back for the second address.
- R4: If control bit 3 is set, bits 31:16 of the control word give an item key. That key is selected before any data moves, and the item offset is reset to 0.
- R5: If control bit 1 is set, the engine copies item bytes one per handshake to ascending target addresses, starting at the current offset. Bit 1 takes priority over bit 2.
- R6: If neither bit 1 nor bit 2 is set, no data write is issued and the offset does not change.
- R7: If the key is invalid, the item is empty, or the offset has reached the item's end, a read writes 0x00 for each remaining byte. A skip in the same case consumes the remaining count with no write.
- R8: If control bit 2 is set and bit 1 is clear, the offset advances by the lesser of the count and the bytes left in the item. No memory write is issued.
- R9: The item offset carries over between transfers that do not select.
- R10: A data write that returns `mem_err` ends the move. No further data write follows it.
- R11: At the end of every transfer, 4 bytes are written at descriptor +0..+3 in big-endian order. The value is 0x00000000 on success and 0x00000001 after an error.
- R12: If a descriptor read returns `mem_err`, no data moves and only the status 0x00000001 is written.
- R13: The store holds NUM_ITEMS items. Item k has length k*LEN_STEP bytes, so item 0 is empty. The byte at offset o is (16*k + o) mod 256. Keys at or above NUM_ITEMS are invalid.
- R14: While `mem_req` is high and `mem_ready` is low, the request, address, direction and write data stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Start pulse; ignored while busy |
| trig_addr | input | ADDR_W | Descriptor address captured with `trig` |
| busy | output | 1 | High from an accepted trigger until the status is written |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write byte |
| mem_rdata | input | 8 | Read byte, valid with `mem_ready` |
| mem_ready | input | 1 | Completes the access in this cycle |
| mem_err | input | 1 | Access failed, valid with `mem_ready` |

## Verification
Copy transfers run in three forms: after a fresh select, as a continuation of an earlier offset, and with both read and skip set. Together they separate offset reset, offset carry-over and the read-over-skip priority. Counts that reach past an item's end, an empty item and an out-of-range key each check the zero-fill path against real data. Skips are checked twice, once within the item and once beyond it, by reading afterwards, along with a do-nothing control and a zero count. Failures on a data write, on a descriptor fetch and a trigger arriving mid-transfer test how the engine stops and what status it writes back. A run with a pseudo-random `mem_ready` pattern confirms that stalls change none of the results.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;

    // Control word bit positions (fixed by the descriptor format)
    localparam int CTL_ERR_BIT  = 0;
    localparam int CTL_RD_BIT   = 1;
    localparam int CTL_SKIP_BIT = 2;
    localparam int CTL_SEL_BIT  = 3;
    localparam int CTL_KEY_LSB  = 16;

    // Descriptor geometry, big-endian, bytes
    localparam int DESC_BYTES   = 16;
    localparam int DESC_W       = DESC_BYTES * 8;
    localparam int STAT_BYTES   = 4;
    localparam int DESC_CTL_LSB = 96;
    localparam int DESC_LEN_LSB = 64;
    localparam int DESC_TGT_LSB = 0;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_FETCH,
        ST_SEL,
        ST_MOVE,
        ST_WB
    } seq_state_e;

    typedef enum logic [1:0] {
        MV_NONE,
        MV_READ,
        MV_SKIP
    } move_kind_e;

endpackage

// File: rtl/cfg_item_store.sv
module cfg_item_store #(
    parameter int NUM_ITEMS = 8,
    parameter int LEN_STEP  = 4,
    parameter int KEY_W     = 16,
    parameter int OFF_W     = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_en,
    input  logic [KEY_W-1:0] sel_key,
    input  logic             adv_en,
    input  logic [OFF_W-1:0] adv_amt,
    output logic [OFF_W-1:0] bytes_left,
    output logic [7:0]       cur_byte
);

    localparam int IDX_W = (NUM_ITEMS > 1) ? $clog2(NUM_ITEMS) : 1;

    typedef struct packed {
        logic [KEY_W-1:0] key;
        logic [OFF_W-1:0] off;
    } store_t;

    store_t s_d, s_q;

    // Length table, one entry per item
    logic [OFF_W-1:0] len_tab [NUM_ITEMS];

    for (genvar g = 0; g < NUM_ITEMS; g++) begin : g_len
        assign len_tab[g] = OFF_W'(g * LEN_STEP);
    end

    logic             key_ok;
    logic [IDX_W-1:0] idx;
    logic [OFF_W-1:0] item_len;

    assign key_ok   = (32'(s_q.key) < NUM_ITEMS);
    assign idx      = IDX_W'(s_q.key);
    assign item_len = key_ok ? len_tab[idx] : '0;

    assign bytes_left = (s_q.off < item_len) ? (item_len - s_q.off) : '0;
    assign cur_byte   = {s_q.key[3:0], 4'h0} + s_q.off[7:0];

    always_comb begin
        s_d = s_q;
        if (sel_en) begin
            s_d.key = sel_key;
            s_d.off = '0;
        end else if (adv_en) begin
            s_d.off = s_q.off + adv_amt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    // A select always lands on offset zero
    p_sel_clears_off_r4 : assert property (@(posedge clk) disable iff (!rst_n)
        sel_en |=> (s_q.off == '0));

    // Offset never passes the end of a valid item
    p_off_in_item_r13 : assert property (@(posedge clk) disable iff (!rst_n)
        key_ok |-> (s_q.off <= item_len));

    // The sequencer only advances within the bytes that remain
    p_adv_bounded_r7 : assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |-> ((adv_amt != '0) && (adv_amt <= bytes_left)));

endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
    import cfg_dma_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int LEN_W  = 32,
    parameter int KEY_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [ADDR_W-1:0] trig_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err,
    output logic              sel_en,
    output logic [KEY_W-1:0]  sel_key,
    output logic              adv_en,
    output logic [LEN_W-1:0]  adv_amt,
    input  logic [LEN_W-1:0]  bytes_left,
    input  logic [7:0]        cur_byte
);

    localparam int CNT_W   = $clog2(DESC_BYTES);
    localparam int LAST_FB = DESC_BYTES - 1;
    localparam int LAST_WB = STAT_BYTES - 1;

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] lat_addr;
        logic [ADDR_W-1:0] base;
        logic [DESC_W-1:0] desc;
        logic [ADDR_W-1:0] tgt;
        logic [LEN_W-1:0]  len;
        move_kind_e        kind;
        logic [CNT_W-1:0]  cnt;
        logic              err;
    } seq_t;

    seq_t q, d;

    logic [31:0]      ctl_w;
    logic [LEN_W-1:0] chunk;
    logic             have_data;

    assign ctl_w     = q.desc[DESC_CTL_LSB +: 32];
    assign have_data = (bytes_left != '0);
    assign chunk     = !have_data ? q.len :
                       ((q.len < bytes_left) ? q.len : bytes_left);

    always_comb begin
        d         = q;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        sel_en    = 1'b0;
        sel_key   = '0;
        adv_en    = 1'b0;
        adv_amt   = '0;

        unique case (q.st)
            ST_IDLE: begin
                if (trig) begin
                    d.lat_addr = trig_addr;
                    d.st       = ST_START;
                end
            end

            ST_START: begin
                d.base     = q.lat_addr;
                d.lat_addr = '0;
                d.cnt      = '0;
                d.err      = 1'b0;
                d.st       = ST_FETCH;
            end

            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = q.base + ADDR_W'(q.cnt);
                if (mem_ready) begin
                    if (mem_err) begin
                        d.err = 1'b1;
                        d.cnt = '0;
                        d.st  = ST_WB;
                    end else begin
                        d.desc = {q.desc[DESC_W-9:0], mem_rdata};
                        d.cnt  = q.cnt + CNT_W'(1);
                        if (q.cnt == CNT_W'(LAST_FB)) begin
                            d.st = ST_SEL;
                        end
                    end
                end
            end

            ST_SEL: begin
                sel_en  = ctl_w[CTL_SEL_BIT];
                sel_key = ctl_w[CTL_KEY_LSB +: KEY_W];
                d.tgt   = ADDR_W'(q.desc[DESC_TGT_LSB +: 64]);
                d.len   = LEN_W'(q.desc[DESC_LEN_LSB +: 32]);
                if (ctl_w[CTL_RD_BIT]) begin
                    d.kind = MV_READ;
                end else if (ctl_w[CTL_SKIP_BIT]) begin
                    d.kind = MV_SKIP;
                end else begin
                    d.kind = MV_NONE;
                    d.len  = '0;
                end
                d.st = ST_MOVE;
            end

            ST_MOVE: begin
                if (q.len == '0) begin
                    d.cnt = '0;
                    d.st  = ST_WB;
                end else begin
                    unique case (q.kind)
                        MV_READ: begin
                            mem_req   = 1'b1;
                            mem_we    = 1'b1;
                            mem_addr  = q.tgt;
                            mem_wdata = have_data ? cur_byte : 8'h00;
                            if (mem_ready) begin
                                if (mem_err) begin
                                    d.err = 1'b1;
                                    d.cnt = '0;
                                    d.st  = ST_WB;
                                end else begin
                                    d.tgt   = q.tgt + ADDR_W'(1);
                                    d.len   = q.len - LEN_W'(1);
                                    adv_en  = have_data;
                                    adv_amt = LEN_W'(1);
                                end
                            end
                        end
                        MV_SKIP: begin
                            adv_en  = have_data;
                            adv_amt = chunk;
                            d.len   = q.len - chunk;
                        end
                        default: begin
                            d.len = '0;
                        end
                    endcase
                end
            end

            ST_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = q.base + ADDR_W'(q.cnt);
                mem_wdata = (q.cnt == CNT_W'(LAST_WB)) ? {7'b0, q.err} : 8'h00;
                if (mem_ready) begin
                    d.cnt = q.cnt + CNT_W'(1);
                    if (q.cnt == CNT_W'(LAST_WB)) begin
                        d.st = ST_IDLE;
                    end
                end
            end

            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.kind <= MV_NONE;
        end else begin
            q <= d;
        end
    end

    assign busy = (q.st != ST_IDLE);

    logic unused_ctl;
    assign unused_ctl = ^{ctl_w[CTL_KEY_LSB-1:CTL_SEL_BIT+1], ctl_w[CTL_ERR_BIT]};

    // No memory traffic while idle
    p_idle_no_req_r1 : assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

    // Descriptor fetch only reads, with the trigger latch already cleared
    p_fetch_reads_r2 : assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FETCH) |-> (!mem_we && (q.lat_addr == '0)));

    // A trigger while busy never restarts the sequence
    p_trig_ignored_r3 : assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trig && (q.st != ST_WB)) |=> (q.st != ST_START));

    // Skip steps issue no memory access
    p_skip_quiet_r8 : assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_MOVE) && (q.kind == MV_SKIP)) |-> !mem_req);

    // A failed data write goes straight to status write-back
    p_err_stops_r10 : assert property (@(posedge clk) disable iff (!rst_n)
        ((q.st == ST_MOVE) && mem_req && mem_ready && mem_err) |=> (q.st == ST_WB));

    // Requests are held until accepted
    p_req_hold_r14 : assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr)
                                     && $stable(mem_we) && $stable(mem_wdata)));

endmodule

// File: rtl/cfg_dma_engine.sv
module cfg_dma_engine #(
    parameter int ADDR_W    = 64,
    parameter int LEN_W     = 32,
    parameter int KEY_W     = 16,
    parameter int NUM_ITEMS = 8,
    parameter int LEN_STEP  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic [ADDR_W-1:0] trig_addr,
    output logic              busy,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    input  logic              mem_ready,
    input  logic              mem_err
);

    logic             sel_en;
    logic [KEY_W-1:0] sel_key;
    logic             adv_en;
    logic [LEN_W-1:0] adv_amt;
    logic [LEN_W-1:0] bytes_left;
    logic [7:0]       cur_byte;

    cfg_dma_seq #(
        .ADDR_W (ADDR_W),
        .LEN_W  (LEN_W),
        .KEY_W  (KEY_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .trig_addr  (trig_addr),
        .busy       (busy),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata),
        .mem_rdata  (mem_rdata),
        .mem_ready  (mem_ready),
        .mem_err    (mem_err),
        .sel_en     (sel_en),
        .sel_key    (sel_key),
        .adv_en     (adv_en),
        .adv_amt    (adv_amt),
        .bytes_left (bytes_left),
        .cur_byte   (cur_byte)
    );

    cfg_item_store #(
        .NUM_ITEMS (NUM_ITEMS),
        .LEN_STEP  (LEN_STEP),
        .KEY_W     (KEY_W),
        .OFF_W     (LEN_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_en     (sel_en),
        .sel_key    (sel_key),
        .adv_en     (adv_en),
        .adv_amt    (adv_amt),
        .bytes_left (bytes_left),
        .cur_byte   (cur_byte)
    );

endmodule

// File: tb/cfg_dma_engine_tb.sv
module cfg_dma_engine_tb;

    localparam int CLK_PERIOD = 10;
    localparam int MEM_BYTES  = 8192;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        trig = 1'b0;
    logic [63:0] trig_addr = '0;
    logic        busy;
    logic        mem_req, mem_we;
    logic [63:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        mem_ready = 1'b1;
    logic        mem_err;

    logic [7:0]  mem [0:MEM_BYTES-1];
    int          n_cmp = 0;
    int          n_bad = 0;
    int          wr_cnt = 0;
    int          err_cnt = 0;
    logic        stall_en = 1'b0;
    logic [7:0]  lfsr = 8'hA1;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_dma_engine u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig      (trig),
        .trig_addr (trig_addr),
        .busy      (busy),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ready (mem_ready),
        .mem_err   (mem_err)
    );

    // Memory model: 8 KiB; beyond it everything faults; page 0x1F00 faults on reads
    assign mem_err   = (mem_addr[63:13] != '0) || (!mem_we && mem_addr[12:8] == 5'h1F);
    assign mem_rdata = mem[mem_addr[12:0]];

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            if (mem_err) err_cnt = err_cnt + 1;
            if (mem_we) begin
                wr_cnt = wr_cnt + 1;
                if (!mem_err) mem[mem_addr[12:0]] = mem_wdata;
            end
        end
    end

    always @(negedge clk) begin
        lfsr      <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        mem_ready <= stall_en ? lfsr[0] : 1'b1;
    end

    function automatic logic [7:0] item_byte(int k, int o);
        return 8'((k * 16 + o) % 256);
    endfunction

    task automatic fill(int a, int n, logic [7:0] v);
        for (int i = 0; i < n; i++) mem[a + i] = v;
    endtask

    task automatic put_desc(int a, logic [31:0] ctl, logic [31:0] len, logic [63:0] tgt);
        for (int i = 0; i < 4; i++) mem[a + i]     = ctl[31 - 8*i -: 8];
        for (int i = 0; i < 4; i++) mem[a + 4 + i] = len[31 - 8*i -: 8];
        for (int i = 0; i < 8; i++) mem[a + 8 + i] = tgt[63 - 8*i -: 8];
    endtask

    task automatic check_byte(string req, int a, logic [7:0] exp);
        n_cmp++;
        if (mem[a] !== exp) begin
            n_bad++;
            $display("FAIL %s: mem[%h] got %h expected %h", req, a, mem[a], exp);
        end
    endtask

    task automatic check_val(string req, string what, int got, int exp);
        n_cmp++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s: %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    task automatic check_status(string req, int a, logic [31:0] exp);
        for (int i = 0; i < 4; i++) check_byte(req, a + i, exp[31 - 8*i -: 8]);
    endtask

    task automatic pulse(int a);
        @(negedge clk);
        trig      = 1'b1;
        trig_addr = 64'(a);
        @(negedge clk);
        trig      = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run(int a);
        pulse(a);
        check_val("R2", "busy after trigger", int'(busy), 1);
        wait_idle();
    endtask

    // R1: reset state and default selection of empty item 0
    task automatic t_reset();
        check_val("R1", "busy", int'(busy), 0);
        check_val("R1", "mem_req", int'(mem_req), 0);
        fill(16'h400, 4, 8'hEE);
        put_desc(16'h100, 32'h0000_0002, 3, 64'h400);
        run(16'h100);
        for (int i = 0; i < 3; i++) check_byte("R1", 16'h400 + i, 8'h00);
        check_byte("R1", 16'h403, 8'hEE);
        check_status("R11", 16'h100, 32'h0);
    endtask

    // R4 R5 R13: select item 3 then copy 8 bytes
    task automatic t_sel_read();
        fill(16'h420, 9, 8'hEE);
        put_desc(16'h110, 32'h0003_000A, 8, 64'h420);
        run(16'h110);
        for (int i = 0; i < 8; i++) check_byte("R5", 16'h420 + i, item_byte(3, i));
        check_byte("R5", 16'h428, 8'hEE);
        check_status("R11", 16'h110, 32'h0);
    endtask

    // R9 R7: continuation past the end of item 3 (length 12)
    task automatic t_continue();
        fill(16'h440, 11, 8'hEE);
        put_desc(16'h120, 32'h0000_0002, 10, 64'h440);
        run(16'h120);
        for (int i = 0; i < 4; i++) check_byte("R9", 16'h440 + i, item_byte(3, 8 + i));
        for (int i = 4; i < 10; i++) check_byte("R7", 16'h440 + i, 8'h00);
        check_byte("R7", 16'h44A, 8'hEE);
    endtask

    // R8: skip within item 5 (length 20), then skip past its end
    task automatic t_skip();
        int w0;
        fill(16'h460, 8, 8'hEE);
        put_desc(16'h130, 32'h0005_000C, 6, 64'h460);
        w0 = wr_cnt;
        run(16'h130);
        check_val("R8", "writes during skip (status only)", wr_cnt - w0, 4);
        for (int i = 0; i < 8; i++) check_byte("R8", 16'h460 + i, 8'hEE);
        put_desc(16'h140, 32'h0000_0002, 4, 64'h480);
        run(16'h140);
        for (int i = 0; i < 4; i++) check_byte("R8", 16'h480 + i, item_byte(5, 6 + i));
        put_desc(16'h150, 32'h0000_0004, 100, 64'h4A0);
        fill(16'h4A0, 4, 8'hEE);
        run(16'h150);
        check_byte("R7", 16'h4A0, 8'hEE);
        check_status("R7", 16'h150, 32'h0);
        fill(16'h4C0, 3, 8'hEE);
        put_desc(16'h160, 32'h0000_0002, 2, 64'h4C0);
        run(16'h160);
        check_byte("R7", 16'h4C0, 8'h00);
        check_byte("R7", 16'h4C1, 8'h00);
        check_byte("R7", 16'h4C2, 8'hEE);
    endtask

    // R6 R4: select-only control moves nothing; offset starts at 0
    task automatic t_none();
        int w0;
        fill(16'h4E0, 6, 8'hEE);
        put_desc(16'h170, 32'h0002_0008, 5, 64'h4E0);
        w0 = wr_cnt;
        run(16'h170);
        check_val("R6", "writes (status only)", wr_cnt - w0, 4);
        check_byte("R6", 16'h4E0, 8'hEE);
        put_desc(16'h180, 32'h0000_0002, 2, 64'h500);
        run(16'h180);
        check_byte("R4", 16'h500, item_byte(2, 0));
        check_byte("R4", 16'h501, item_byte(2, 1));
    endtask

    // R5: read and skip both set -> read wins
    task automatic t_prio();
        put_desc(16'h190, 32'h0006_000E, 3, 64'h520);
        run(16'h190);
        for (int i = 0; i < 3; i++) check_byte("R5", 16'h520 + i, item_byte(6, i));
    endtask

    // R7 R13: invalid key reads zeros; zero count writes nothing
    task automatic t_invalid_len0();
        fill(16'h540, 4, 8'hEE);
        put_desc(16'h1A0, 32'h0100_000A, 3, 64'h540);
        run(16'h1A0);
        for (int i = 0; i < 3; i++) check_byte("R13", 16'h540 + i, 8'h00);
        check_byte("R13", 16'h543, 8'hEE);
        fill(16'h560, 2, 8'hEE);
        put_desc(16'h1B0, 32'h0001_000A, 0, 64'h560);
        run(16'h1B0);
        check_byte("R6", 16'h560, 8'hEE);
        check_status("R11", 16'h1B0, 32'h0);
    endtask

    // R10 R11: write fault at 0x2000 stops the copy
    task automatic t_write_err();
        int e0;
        e0 = err_cnt;
        put_desc(16'h1C0, 32'h0007_000A, 4, 64'h1FFE);
        run(16'h1C0);
        check_byte("R10", 16'h1FFE, item_byte(7, 0));
        check_byte("R10", 16'h1FFF, item_byte(7, 1));
        check_val("R10", "faulted accesses", err_cnt - e0, 1);
        check_status("R11", 16'h1C0, 32'h1);
    endtask

    // R12: descriptor read faults
    task automatic t_fetch_err();
        int w0;
        fill(16'h1F00, 16, 8'hEE);
        w0 = wr_cnt;
        run(16'h1F00);
        check_val("R12", "writes (status only)", wr_cnt - w0, 4);
        check_status("R12", 16'h1F00, 32'h1);
    endtask

    // R3: second trigger during a transfer is dropped
    task automatic t_busy_ignore();
        fill(16'h5C0, 4, 8'hEE);
        put_desc(16'h1D0, 32'h0004_000A, 16, 64'h580);
        put_desc(16'h1E0, 32'h0000_0002, 4, 64'h5C0);
        pulse(16'h1D0);
        repeat (3) @(negedge clk);
        check_val("R2", "busy mid-transfer", int'(busy), 1);
        pulse(16'h1E0);
        wait_idle();
        repeat (20) @(negedge clk);
        check_val("R3", "busy after drop", int'(busy), 0);
        for (int i = 0; i < 16; i++) check_byte("R3", 16'h580 + i, item_byte(4, i));
        check_byte("R3", 16'h5C0, 8'hEE);
        check_status("R3", 16'h1E0, 32'h0000_0002);
    endtask

    // R14: random stalls give identical results
    task automatic t_stall();
        stall_en = 1'b1;
        fill(16'h600, 29, 8'hEE);
        put_desc(16'h1F0, 32'h0007_000A, 28, 64'h600);
        pulse(16'h1F0);
        wait_idle();
        stall_en = 1'b0;
        for (int i = 0; i < 28; i++) check_byte("R14", 16'h600 + i, item_byte(7, i));
        check_byte("R14", 16'h61C, 8'hEE);
        check_status("R14", 16'h1F0, 32'h0);
    endtask

    initial begin
        for (int i = 0; i < MEM_BYTES; i++) mem[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sel_read();
        t_continue();
        t_skip();
        t_none();
        t_prio();
        t_invalid_len0();
        t_write_err();
        t_fetch_err();
        t_busy_ignore();
        t_stall();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule